// File: doc/BRIEF.md
# Frequency Estimate Arbiter with Fault Ride-Through

This block picks the system frequency value that downstream controllers use. It has two estimates to choose from. The first comes from the rotating space vector of the three phase voltages: it settles quickly, but it can be wrong during faults. The second comes from a locked loop: it is slower and more robust once it has locked. The block sees every estimate once per 2 ms frame, marked by a 500 Hz frame strobe. On each frame it applies the following rules, in this order:

- If the loop reports lock, its estimate is passed straight through.
- If the loop is not locked, the block checks the per-frame angle step of the space vector against a programmable window. If the step is inside the window, the fast estimate is used. It is also presented as a seed for the loop and as a preload for the long frequency averagers.
- If neither estimate can be trusted, as in a deep three-phase dip, the output holds the last good frequency. The averagers are preloaded with that held value once. A configurable frame budget then limits how long the hold lasts. When the budget runs out, the block flags the frequency as invalid and waits for a trusted estimate to return.

Separately, a frame counter tracks how long measurable voltage has been present. It enables the two cascaded averaging stages one after the other, at 50 and 80 frames (100 ms and 160 ms). The response therefore widens from one cycle to three cycles and then to five cycles.

Top module: `freq_arbiter`

## Requirements
- R1: On each frame strobe, `fast_ok` is registered high exactly when `step_lo <= ang_step <= step_hi`, with all three values compared as signed numbers. Both limits are inclusive.
- R2: On a frame with `loop_locked` high, the block registers `loop_freq` onto `freq_out` and raises neither strobe.
- R3: On a frame with `loop_locked` low and the fast estimate valid, `freq_out` and `fill_val` take `fast_freq`. Both `seed_stb` and `preload_stb` pulse for one clock. This happens on every such frame.
- R4: On the first frame where neither estimate is valid, coming from a trusted state, the block enters ride-through. `hold_act` rises, `freq_out` keeps the last good value, and `preload_stb` pulses once with `fill_val` equal to that value. `seed_stb` stays low.
- R5: The last good value is the selected estimate of the most recent frame on which an estimate was valid and `volts_ok` was high. Frames where `volts_ok` is low do not change it.
- R6: Count the ride-through entry frame as frame 0. If no estimate returns, then on frame `ride_max` after entry `hold_act` falls, `freq_invalid` rises and `freq_out` stays held. `freq_invalid` and `hold_act` are never high together.
- R7: While the frequency is invalid, the first frame that has a valid estimate clears `freq_invalid` and selects that estimate, following the rules of R2 and R3.
- R8: A frame with `volts_ok` low clears both stage enables and restarts the count. After that, counting frames with `volts_ok` high, `stage1_en` rises on the 50th and `stage2_en` on the 80th. `stage2_en` never rises without `stage1_en`.
- R9: During reset, `freq_out`, `fill_val` and all strobes and flags are 0, except `freq_invalid`, which is 1. The last good value is 0.
- R10: Outputs change only on clocks where `frame_tick` is sampled high. Strobes last exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-clock frame strobe, 500 Hz |
| fast_freq | input | FW | Space-vector frequency estimate |
| loop_freq | input | FW | Locked-loop frequency estimate |
| ang_step | input | AW | Signed space-vector angle step per frame |
| step_lo | input | AW | Signed lower limit of a valid step |
| step_hi | input | AW | Signed upper limit of a valid step |
| loop_locked | input | 1 | Locked loop reports lock |
| volts_ok | input | 1 | Measurable voltage present |
| ride_max | input | CW | Ride-through budget in frames |
| freq_out | output | FW | Selected frequency |
| seed_stb | output | 1 | Load the loop frequency from `fill_val` |
| preload_stb | output | 1 | Load the long averagers from `fill_val` |
| fill_val | output | FW | Seed / preload value |
| fast_ok | output | 1 | Fast estimate judged valid this frame |
| hold_act | output | 1 | Ride-through hold in progress |
| freq_invalid | output | 1 | Ride-through expired, or no estimate since reset |
| stage1_en | output | 1 | First cascaded averaging stage switched in |
| stage2_en | output | 1 | Second cascaded averaging stage switched in |

## Verification
Suppose the block ends up in the wrong arbitration mode. The symptom shows on the next frame strobe, as a `freq_out` taken from the wrong source or as a missing or extra seed strobe. A last good value that was corrupted stays hidden until the next ride-through entry, so the stimulus includes dips right after frames where the voltage was absent. A ride-through counter that is off by one moves the rise of `freq_invalid` by exactly one frame. A stage counter that is off by one moves the stage enables by one frame, and this only shows after 50 or 80 frames of stable voltage.

// File: rtl/freq_arb_pkg.sv
package freq_arb_pkg;
  typedef enum logic [1:0] {
    M_LOST = 2'd0,
    M_RIDE = 2'd1,
    M_SEED = 2'd2,
    M_LOCK = 2'd3
  } arb_mode_t;
endpackage

// File: rtl/step_window.sv
module step_window #(
  parameter int AW = 16
) (
  input  logic signed [AW-1:0] step,
  input  logic signed [AW-1:0] lim_lo,
  input  logic signed [AW-1:0] lim_hi,
  output logic                 in_win
);
  always_comb begin
    in_win = (step >= lim_lo) && (step <= lim_hi);
  end
endmodule

// File: rtl/stage_timer.sv
module stage_timer #(
  parameter int T1 = 50,
  parameter int T2 = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic volts,
  output logic en1,
  output logic en2
);
  localparam int SW = $clog2(T2 + 1);
  localparam logic [SW-1:0] T1_V = SW'(T1);
  localparam logic [SW-1:0] T2_V = SW'(T2);

  logic [SW-1:0] up_q, up_d;

  always_comb begin
    up_d = up_q;
    if (tick) begin
      if (!volts)
        up_d = '0;
      else if (up_q < T2_V)
        up_d = up_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= '0;
    else        up_q <= up_d;
  end

  assign en1 = (up_q >= T1_V);
  assign en2 = (up_q >= T2_V);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import freq_arb_pkg::*;
#(
  parameter int FW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fv,
  input  logic          locked,
  input  logic          volts,
  input  logic [FW-1:0] fast,
  input  logic [FW-1:0] loop,
  input  logic [CW-1:0] ride_max,
  output logic [FW-1:0] freq,
  output logic          seed,
  output logic          pre,
  output logic [FW-1:0] fill,
  output logic          fok,
  output logic          hold,
  output logic          inval
);
  arb_mode_t     mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic [FW-1:0] good_q, good_d, freq_q, freq_d, fill_q, fill_d;
  logic          seed_q, seed_d, pre_q, pre_d, fok_q, fok_d;

  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    good_d = good_q;
    freq_d = freq_q;
    fill_d = fill_q;
    fok_d  = fok_q;
    seed_d = 1'b0;
    pre_d  = 1'b0;
    if (tick) begin
      fok_d = fv;
      if ((locked || fv) && volts)
        good_d = locked ? loop : fast;
      if (locked) begin
        mode_d = M_LOCK;
        freq_d = loop;
      end else if (fv) begin
        mode_d = M_SEED;
        freq_d = fast;
        fill_d = fast;
        seed_d = 1'b1;
        pre_d  = 1'b1;
      end else begin
        freq_d = good_q;
        unique case (mode_q)
          M_LOCK, M_SEED: begin
            mode_d = M_RIDE;
            cnt_d  = '0;
            fill_d = good_q;
            pre_d  = 1'b1;
          end
          M_RIDE: begin
            if (cnt_inc >= {1'b0, ride_max}) mode_d = M_LOST;
            else                             cnt_d  = cnt_inc[CW-1:0];
          end
          default: mode_d = M_LOST;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_LOST;
      cnt_q  <= '0;
      good_q <= '0;
      freq_q <= '0;
      fill_q <= '0;
      fok_q  <= 1'b0;
      seed_q <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      good_q <= good_d;
      freq_q <= freq_d;
      fill_q <= fill_d;
      fok_q  <= fok_d;
      seed_q <= seed_d;
      pre_q  <= pre_d;
    end
  end

  assign freq  = freq_q;
  assign seed  = seed_q;
  assign pre   = pre_q;
  assign fill  = fill_q;
  assign fok   = fok_q;
  assign hold  = (mode_q == M_RIDE);
  assign inval = (mode_q == M_LOST);
endmodule

// File: rtl/freq_arbiter.sv
module freq_arbiter #(
  parameter int FW = 16,
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int STAGE1_FRAMES = 50,
  parameter int STAGE2_FRAMES = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic [FW-1:0]        fast_freq,
  input  logic [FW-1:0]        loop_freq,
  input  logic signed [AW-1:0] ang_step,
  input  logic signed [AW-1:0] step_lo,
  input  logic signed [AW-1:0] step_hi,
  input  logic                 loop_locked,
  input  logic                 volts_ok,
  input  logic [CW-1:0]        ride_max,
  output logic [FW-1:0]        freq_out,
  output logic                 seed_stb,
  output logic                 preload_stb,
  output logic [FW-1:0]        fill_val,
  output logic                 fast_ok,
  output logic                 hold_act,
  output logic                 freq_invalid,
  output logic                 stage1_en,
  output logic                 stage2_en
);
  logic win_ok;

  step_window #(.AW(AW)) win_i (
    .step(ang_step), .lim_lo(step_lo), .lim_hi(step_hi), .in_win(win_ok)
  );

  arb_fsm #(.FW(FW), .CW(CW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .fv(win_ok),
    .locked(loop_locked), .volts(volts_ok), .fast(fast_freq),
    .loop(loop_freq), .ride_max(ride_max), .freq(freq_out),
    .seed(seed_stb), .pre(preload_stb), .fill(fill_val), .fok(fast_ok),
    .hold(hold_act), .inval(freq_invalid)
  );

  stage_timer #(.T1(STAGE1_FRAMES), .T2(STAGE2_FRAMES)) stg_i (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .volts(volts_ok),
    .en1(stage1_en), .en2(stage2_en)
  );
endmodule

// File: rtl/freq_arbiter_chk.sv
module freq_arbiter_chk #(
  parameter int FW = 16,
  parameter int AW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_tick,
  input logic [FW-1:0]        loop_freq,
  input logic signed [AW-1:0] ang_step,
  input logic signed [AW-1:0] step_lo,
  input logic signed [AW-1:0] step_hi,
  input logic                 loop_locked,
  input logic                 volts_ok,
  input logic [FW-1:0]        freq_out,
  input logic                 seed_stb,
  input logic                 preload_stb,
  input logic [FW-1:0]        fill_val,
  input logic                 fast_ok,
  input logic                 hold_act,
  input logic                 freq_invalid,
  input logic                 stage1_en,
  input logic                 stage2_en
);
  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> fast_ok == (($past(ang_step) >= $past(step_lo)) &&
                               ($past(ang_step) <= $past(step_hi))));

  assert_locked_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && loop_locked) |=> (!seed_stb && !preload_stb &&
                                     freq_out == $past(loop_freq)));

  assert_seed_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_stb |-> (preload_stb && fill_val == freq_out));

  assert_flags_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(freq_invalid && hold_act));

  assert_stage_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_en |-> stage1_en);

  assert_dip_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !volts_ok) |=> (!stage1_en && !stage2_en));

  assert_quiet_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(freq_out) && $stable(freq_invalid) &&
                     !seed_stb && !preload_stb));
endmodule

bind freq_arbiter freq_arbiter_chk #(.FW(FW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .loop_freq(loop_freq),
  .ang_step(ang_step), .step_lo(step_lo), .step_hi(step_hi),
  .loop_locked(loop_locked), .volts_ok(volts_ok), .freq_out(freq_out),
  .seed_stb(seed_stb), .preload_stb(preload_stb), .fill_val(fill_val),
  .fast_ok(fast_ok), .hold_act(hold_act), .freq_invalid(freq_invalid),
  .stage1_en(stage1_en), .stage2_en(stage2_en)
);

// File: tb/freq_arbiter_tb_top.sv
`timescale 1ns/1ps
module freq_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic [15:0] fast_freq = '0, loop_freq = '0;
  logic signed [15:0] ang_step = '0, step_lo = 16'sd100, step_hi = 16'sd400;
  logic loop_locked = 1'b0, volts_ok = 1'b0;
  logic [7:0] ride_max = 8'd5;
  logic [15:0] freq_out, fill_val;
  logic seed_stb, preload_stb, fast_ok, hold_act, freq_invalid, stage1_en, stage2_en;

  freq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fast_freq(fast_freq),
    .loop_freq(loop_freq), .ang_step(ang_step), .step_lo(step_lo),
    .step_hi(step_hi), .loop_locked(loop_locked), .volts_ok(volts_ok),
    .ride_max(ride_max), .freq_out(freq_out), .seed_stb(seed_stb),
    .preload_stb(preload_stb), .fill_val(fill_val), .fast_ok(fast_ok),
    .hold_act(hold_act), .freq_invalid(freq_invalid),
    .stage1_en(stage1_en), .stage2_en(stage2_en)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: mode 0 invalid, 1 riding, 2 seeding, 3 locked
  int m_mode = 0, m_cnt = 0, m_up = 0;
  int m_good = 0, m_freq = 0, m_fill = 0;
  bit m_seed = 0, m_pre = 0, m_fok = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R5 freq_out", freq_out, m_freq);
    chk("R3/R10 seed_stb", seed_stb, m_seed);
    chk("R3/R4/R10 preload_stb", preload_stb, m_pre);
    chk("R3/R4 fill_val", fill_val, m_fill);
    chk("R1 fast_ok", fast_ok, m_fok);
    chk("R4/R6 hold_act", hold_act, m_mode == 1);
    chk("R6/R7 freq_invalid", freq_invalid, m_mode == 0);
    chk("R8 stage1_en", stage1_en, m_up >= 50);
    chk("R8 stage2_en", stage2_en, m_up >= 80);
  endtask

  task automatic model_frame();
    bit fv;
    fv = (int'(ang_step) >= int'(step_lo)) && (int'(ang_step) <= int'(step_hi));
    m_fok = fv;
    m_seed = 0;
    m_pre = 0;
    if (loop_locked) begin
      m_mode = 3; m_freq = loop_freq;
    end else if (fv) begin
      m_mode = 2; m_freq = fast_freq; m_fill = fast_freq; m_seed = 1; m_pre = 1;
    end else begin
      m_freq = m_good;
      if (m_mode >= 2) begin
        m_mode = 1; m_cnt = 0; m_pre = 1; m_fill = m_good;
      end else if (m_mode == 1) begin
        if (m_cnt + 1 >= int'(ride_max)) m_mode = 0;
        else m_cnt++;
      end
    end
    if ((loop_locked || fv) && volts_ok) m_good = loop_locked ? loop_freq : fast_freq;
    if (!volts_ok) m_up = 0;
    else if (m_up < 80) m_up++;
  endtask

  // one frame = 4 clocks; compare at each falling edge, drive, then model
  task automatic frame(input bit lk, input bit vo, input int fs, input int lp, input int st);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      compare_all();
      loop_locked = lk; volts_ok = vo; fast_freq = 16'(fs); loop_freq = 16'(lp);
      ang_step = 16'(st);
      frame_tick = (c == 0);
      if (c == 0) model_frame();
      else begin m_seed = 0; m_pre = 0; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 freq_out", freq_out, 0);
    chk("R9 freq_invalid", freq_invalid, 1);
    chk("R9 strobes", {seed_stb, preload_stb, hold_act, stage1_en}, 0);
    rst_n = 1'b1;
    // R1 boundaries, R3 seeding on every valid frame, R7 leaves invalid
    frame(0, 1, 5000, 0, 100);
    frame(0, 1, 5001, 0, 400);
    frame(0, 1, 5002, 0, 99);
    frame(0, 1, 5003, 0, 401);
    for (int i = 0; i < 6; i++) frame(0, 1, 5010 + i, 0, 250);
    // R2 locked pass-through
    for (int i = 0; i < 6; i++) frame(1, 1, 1, 4990 + i, 999);
    // R4 short dip, recovered before budget
    frame(0, 0, 7777, 0, -50);
    frame(0, 0, 7777, 0, -50);
    frame(0, 1, 5020, 0, 200);
    // R5: valid frame without voltage must not change last good
    frame(0, 0, 6000, 0, 200);
    frame(0, 0, 1, 0, 0);
    // R6 long dip with timeout, then R7 recovery through lock
    for (int i = 0; i < 9; i++) frame(0, 0, 1, 0, 0);
    frame(1, 1, 0, 5050, 0);
    // R8 staging after voltage return
    for (int i = 0; i < 85; i++) frame(1, 1, 0, 5000 + (i % 3), 0);
    ride_max = 8'd1;
    frame(0, 1, 0, 0, 1000);
    frame(0, 1, 0, 0, 1000);
    frame(0, 1, 0, 0, 1000);
    ride_max = 8'd4;
    // mixed random patterns
    for (int i = 0; i < 400; i++)
      frame(($urandom % 4) == 0, ($urandom % 8) != 0, 4900 + $urandom % 200,
            4900 + $urandom % 200, int'($urandom % 600) - 100);
    @(negedge clk);
    compare_all();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++;
            $display("FAIL watchdog expired"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule